// File: doc/BRIEF.md
# Operand Effective Address Generator

This unit works out where an operand lives. Each operand carries its own 4-bit mode specifier, kept apart from the operation bits, so any mode pairs with any operation. From that specifier, a 16-entry pointer register file, a 16-bit constant taken from the instruction and the program counter, the unit forms a 32-bit effective address. It also raises flags that tell the rest of the pipeline whether the operand is an immediate value, whether a memory access is needed, or whether the encoding is undefined.

Index scaling uses a left shift of 0 to 3 places, so element sizes are 1, 2, 4 or 8. The two self-modifying modes, post-increment and pre-decrement, write the updated pointer back into the register file on the clock edge where the operand strobe is high. Together these two modes give a stack: push with pre-decrement, pop with post-increment on the same register. A separate write port lets the execution stage load result values into the register file.

Top module: `opnd_addr_gen`

## Requirements
- R1: After reset every register reads as zero through register-direct mode.
- R2: Mode 0 (register direct) returns the selected register value on effAddr. It raises no memory access and no immediate flag.
- R3: Mode 1 (immediate) returns the 16-bit constant sign-extended to 32 bits. It raises isImm and no memory access.
- R4: Mode 2 (absolute) returns the constant zero-extended to 32 bits, with memAccess high.
- R5: Mode 4 (base plus offset) gives base register plus the sign-extended constant. Mode 3 (register indirect) gives the same result as mode 4 with a zero constant. Both raise memAccess.
- R6: Mode 5 gives base + (index << scale). Mode 6 adds the sign-extended constant to that sum. The scale field is a 2-bit shift count.
- R7: Mode 7 (PC-relative) gives pc plus the sign-extended constant, with memAccess high.
- R8: Mode 8 (post-increment) uses the base register's current value as the address. It drives wbEn and wbData = base + (1 << scale), and writes that value into the base register on the strobed clock edge.
- R9: Mode 9 (pre-decrement) uses base - (1 << scale) as the address and writes the same value back. Pushes with mode 9 and pops with mode 8 on one register restore the pointer and return addresses in last-in first-out order.
- R10: Mode codes 10 to 15 raise illegal. They drive no writeback, no memory access and no immediate flag, and leave the register file unchanged.
- R11: While valid is low, memAccess, isImm, illegal and wbEn stay low, and no register is modified by any mode.
- R12: wrEn writes wrData into register wrSel on the clock edge. When a self-modifying writeback targets the same register in the same cycle, the writeback value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| valid | input | 1 | Operand strobe; enables flags and writeback |
| mode | input | 4 | Addressing mode specifier |
| regA | input | 4 | Base or pointer register select |
| regX | input | 4 | Index register select |
| scale | input | 2 | Index shift count and element size exponent |
| offset | input | 16 | Constant from the instruction |
| pc | input | 32 | Program counter of the current instruction |
| wrEn | input | 1 | Result write enable |
| wrSel | input | 4 | Result write register select |
| wrData | input | 32 | Result write data |
| effAddr | output | 32 | Effective address, or operand value for register direct and immediate |
| isImm | output | 1 | Operand is the immediate constant |
| memAccess | output | 1 | Operand needs a memory access |
| illegal | output | 1 | Undefined mode code |
| wbEn | output | 1 | Pointer writeback active |
| wbReg | output | 4 | Pointer writeback register |
| wbData | output | 32 | Pointer writeback value |

## Verification
Register contents are chosen so that wrong behaviour shows up clearly. A negative index separates signed from unsigned handling. A constant with its top bit set separates sign extension (immediate, offsets) from zero extension (absolute). Each scale from 0 to 3 is used, so a wrong shift count cannot hide. A push-push-pop-pop sequence on one pointer checks that pre-decrement and post-increment use the right ordering of access and update. Idle strobes, undefined codes, and a result write that collides with a writeback are each followed by a register-direct read that shows whether the file was disturbed.

// File: rtl/opnd_pkg.sv
package opnd_pkg;

  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    AM_REG     = 4'd0,
    AM_IMM     = 4'd1,
    AM_ABS     = 4'd2,
    AM_IND     = 4'd3,
    AM_BOFF    = 4'd4,
    AM_BIDX    = 4'd5,
    AM_BIDXOFF = 4'd6,
    AM_PCREL   = 4'd7,
    AM_POSTINC = 4'd8,
    AM_PREDEC  = 4'd9
  } amode_e;

  typedef enum logic [1:0] {
    OFF_NONE = 2'd0,
    OFF_SEXT = 2'd1,
    OFF_ZEXT = 2'd2
  } offSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    baseEn;
    logic    idxEn;
    logic    pcEn;
    offSel_e offSel;
    logic    preDec;
    logic    autoMod;
    logic    memAcc;
    logic    immVal;
    logic    badMode;
  } strobe_t;

endpackage

// File: rtl/opnd_ctrl.sv
module opnd_ctrl
  import opnd_pkg::*;
(
  input  logic              valid,
  input  logic [MODE_W-1:0] mode,
  output strobe_t           stb
);

  strobe_t dec;

  always_comb begin
    dec        = '0;
    dec.offSel = OFF_NONE;
    case (mode)
      AM_REG: begin
        dec.baseEn = 1'b1;
      end
      AM_IMM: begin
        dec.offSel = OFF_SEXT;
        dec.immVal = 1'b1;
      end
      AM_ABS: begin
        dec.offSel = OFF_ZEXT;
        dec.memAcc = 1'b1;
      end
      AM_IND: begin
        dec.baseEn = 1'b1;
        dec.memAcc = 1'b1;
      end
      AM_BOFF: begin
        dec.baseEn = 1'b1;
        dec.offSel = OFF_SEXT;
        dec.memAcc = 1'b1;
      end
      AM_BIDX: begin
        dec.baseEn = 1'b1;
        dec.idxEn  = 1'b1;
        dec.memAcc = 1'b1;
      end
      AM_BIDXOFF: begin
        dec.baseEn = 1'b1;
        dec.idxEn  = 1'b1;
        dec.offSel = OFF_SEXT;
        dec.memAcc = 1'b1;
      end
      AM_PCREL: begin
        dec.pcEn   = 1'b1;
        dec.offSel = OFF_SEXT;
        dec.memAcc = 1'b1;
      end
      AM_POSTINC: begin
        dec.baseEn  = 1'b1;
        dec.autoMod = 1'b1;
        dec.memAcc  = 1'b1;
      end
      AM_PREDEC: begin
        dec.baseEn  = 1'b1;
        dec.preDec  = 1'b1;
        dec.autoMod = 1'b1;
        dec.memAcc  = 1'b1;
      end
      default: begin
        dec.badMode = 1'b1;
      end
    endcase
  end

  // side effects and flags only while the operand strobe is high
  always_comb begin
    stb         = dec;
    stb.autoMod = dec.autoMod & valid;
    stb.memAcc  = dec.memAcc  & valid;
    stb.immVal  = dec.immVal  & valid;
    stb.badMode = dec.badMode & valid;
  end

endmodule

// File: rtl/opnd_dpath.sv
module opnd_dpath
  import opnd_pkg::*;
#(
  parameter int AW   = 32,
  parameter int RN   = 16,
  parameter int OFFW = 16,
  parameter int SCW  = 2,
  localparam int SELW = $clog2(RN)
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         stb,
  input  logic [SELW-1:0] selA,
  input  logic [SELW-1:0] selX,
  input  logic [SCW-1:0]  scale,
  input  logic [OFFW-1:0] offset,
  input  logic [AW-1:0]   pc,
  input  logic            wrEn,
  input  logic [SELW-1:0] wrSel,
  input  logic [AW-1:0]   wrData,
  output logic [AW-1:0]   effAddr,
  output logic [AW-1:0]   wbData
);

  logic [AW-1:0] regVal [RN];

  // one storage entry per register, each with its own write select
  for (genvar g = 0; g < RN; g++) begin : gEntry
    logic [AW-1:0] q;
    logic          autoHit;
    logic          loadHit;
    assign autoHit = stb.autoMod && (selA == SELW'(g));
    assign loadHit = wrEn && (wrSel == SELW'(g));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)        q <= '0;
      else if (autoHit) q <= wbData;
      else if (loadHit) q <= wrData;
    end
    assign regVal[g] = q;
  end

  logic [AW-1:0] baseVal, idxVal, step;
  logic [AW-1:0] baseTerm, idxTerm, offTerm;
  logic [AW-1:0] decPtr, incPtr;

  assign baseVal = regVal[selA];
  assign idxVal  = regVal[selX];
  assign step    = AW'(1) << scale;

  always_comb begin
    if (stb.pcEn)        baseTerm = pc;
    else if (stb.baseEn) baseTerm = baseVal;
    else                 baseTerm = '0;
  end

  assign idxTerm = stb.idxEn ? (idxVal << scale) : '0;

  always_comb begin
    case (stb.offSel)
      OFF_SEXT: offTerm = {{(AW-OFFW){offset[OFFW-1]}}, offset};
      OFF_ZEXT: offTerm = {{(AW-OFFW){1'b0}}, offset};
      default:  offTerm = '0;
    endcase
  end

  assign decPtr  = baseVal - step;
  assign incPtr  = baseVal + step;
  assign effAddr = stb.preDec ? decPtr : (baseTerm + idxTerm + offTerm);
  assign wbData  = stb.preDec ? decPtr : incPtr;

endmodule

// File: rtl/opnd_addr_gen.sv
module opnd_addr_gen
  import opnd_pkg::*;
#(
  parameter int AW   = 32,
  parameter int RN   = 16,
  parameter int OFFW = 16,
  parameter int SCW  = 2,
  localparam int SELW = $clog2(RN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              valid,
  input  logic [MODE_W-1:0] mode,
  input  logic [SELW-1:0]   regA,
  input  logic [SELW-1:0]   regX,
  input  logic [SCW-1:0]    scale,
  input  logic [OFFW-1:0]   offset,
  input  logic [AW-1:0]     pc,
  input  logic              wrEn,
  input  logic [SELW-1:0]   wrSel,
  input  logic [AW-1:0]     wrData,
  output logic [AW-1:0]     effAddr,
  output logic              isImm,
  output logic              memAccess,
  output logic              illegal,
  output logic              wbEn,
  output logic [SELW-1:0]   wbReg,
  output logic [AW-1:0]     wbData
);

  strobe_t stb;

  opnd_ctrl uCtrl (
    .valid (valid),
    .mode  (mode),
    .stb   (stb)
  );

  opnd_dpath #(
    .AW   (AW),
    .RN   (RN),
    .OFFW (OFFW),
    .SCW  (SCW)
  ) uDpath (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .selA    (regA),
    .selX    (regX),
    .scale   (scale),
    .offset  (offset),
    .pc      (pc),
    .wrEn    (wrEn),
    .wrSel   (wrSel),
    .wrData  (wrData),
    .effAddr (effAddr),
    .wbData  (wbData)
  );

  assign isImm     = stb.immVal;
  assign memAccess = stb.memAcc;
  assign illegal   = stb.badMode;
  assign wbEn      = stb.autoMod;
  assign wbReg     = regA;

endmodule

// File: rtl/opnd_chk.sv
module opnd_chk #(
  parameter int AW   = 32,
  parameter int SELW = 4,
  parameter int SCW  = 2
) (
  input logic            clk,
  input logic            rstN,
  input logic            valid,
  input logic [3:0]      mode,
  input logic [SELW-1:0] regA,
  input logic [SCW-1:0]  scale,
  input logic [AW-1:0]   effAddr,
  input logic            isImm,
  input logic            memAccess,
  input logic            illegal,
  input logic            wbEn,
  input logic [SELW-1:0] wbReg,
  input logic [AW-1:0]   wbData
);

  // R2
  a_r2_direct_no_mem: assert property (@(posedge clk) disable iff (!rstN)
    (valid && mode == 4'd0) |-> (!memAccess && !isImm));

  // R3
  a_r3_imm_no_mem: assert property (@(posedge clk) disable iff (!rstN)
    isImm |-> (!memAccess && !wbEn));

  // R8
  a_r8_postinc_step: assert property (@(posedge clk) disable iff (!rstN)
    (valid && mode == 4'd8) |-> (wbEn && wbData == effAddr + (AW'(1) << scale)));

  // R8: the written pointer is what a following direct read returns
  a_r8_wb_visible: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(wbEn) && valid && mode == 4'd0 && regA == $past(wbReg))
      |-> (effAddr == $past(wbData)));

  // R9
  a_r9_predec_addr: assert property (@(posedge clk) disable iff (!rstN)
    (valid && mode == 4'd9) |-> (wbEn && wbData == effAddr));

  // R10
  a_r10_illegal_quiet: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> (!memAccess && !wbEn && !isImm));

  // R11
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !valid |-> !(memAccess || isImm || illegal || wbEn));

endmodule

bind opnd_addr_gen opnd_chk #(
  .AW   (AW),
  .SELW (SELW),
  .SCW  (SCW)
) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .valid     (valid),
  .mode      (mode),
  .regA      (regA),
  .scale     (scale),
  .effAddr   (effAddr),
  .isImm     (isImm),
  .memAccess (memAccess),
  .illegal   (illegal),
  .wbEn      (wbEn),
  .wbReg     (wbReg),
  .wbData    (wbData)
);

// File: tb/sim_opnd_addr_gen.sv
`timescale 1ns/1ps
module sim_opnd_addr_gen;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        valid = 1'b0;
  logic [3:0]  mode = '0;
  logic [3:0]  regA = '0;
  logic [3:0]  regX = '0;
  logic [1:0]  scale = '0;
  logic [15:0] offset = '0;
  logic [31:0] pcIn = '0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrSel = '0;
  logic [31:0] wrData = '0;
  logic [31:0] effAddr, wbData;
  logic        isImm, memAccess, illegal, wbEn;
  logic [3:0]  wbReg;

  always #4 clk = ~clk;

  opnd_addr_gen u0 (
    .clk(clk), .rstN(rstN), .valid(valid), .mode(mode), .regA(regA),
    .regX(regX), .scale(scale), .offset(offset), .pc(pcIn), .wrEn(wrEn),
    .wrSel(wrSel), .wrData(wrData), .effAddr(effAddr), .isImm(isImm),
    .memAccess(memAccess), .illegal(illegal), .wbEn(wbEn), .wbReg(wbReg),
    .wbData(wbData)
  );

  logic [31:0] refRegs [16];
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  task automatic chk32(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic chk1(input string tag, input string what,
                      input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  // one operand per clock; the reference model is updated after the edge
  task automatic op(input bit v, input logic [3:0] m, input logic [3:0] a,
                    input logic [3:0] x, input logic [1:0] sc,
                    input logic [15:0] off, input string tag,
                    input bit ld = 1'b0, input logic [3:0] ldSel = '0,
                    input logic [31:0] ldVal = '0);
    logic [31:0] ea, wbd, sx, step;
    bit mem, imm, ill, wb;
    @(negedge clk);
    valid = v; mode = m; regA = a; regX = x; scale = sc; offset = off;
    wrEn = ld; wrSel = ldSel; wrData = ldVal;
    #2;
    sx = {{16{off[15]}}, off};
    step = 32'd1 << sc;
    ea = '0; wbd = '0; mem = 0; imm = 0; ill = 0; wb = 0;
    case (m)
      4'd0: ea = refRegs[a];
      4'd1: begin ea = sx; imm = 1; end
      4'd2: begin ea = {16'd0, off}; mem = 1; end
      4'd3: begin ea = refRegs[a]; mem = 1; end
      4'd4: begin ea = refRegs[a] + sx; mem = 1; end
      4'd5: begin ea = refRegs[a] + (refRegs[x] << sc); mem = 1; end
      4'd6: begin ea = refRegs[a] + (refRegs[x] << sc) + sx; mem = 1; end
      4'd7: begin ea = pcIn + sx; mem = 1; end
      4'd8: begin ea = refRegs[a]; wbd = refRegs[a] + step; mem = 1; wb = 1; end
      4'd9: begin wbd = refRegs[a] - step; ea = wbd; mem = 1; wb = 1; end
      default: ill = 1;
    endcase
    if (!v) begin mem = 0; imm = 0; ill = 0; wb = 0; end
    if (v && !ill) chk32(tag, "effAddr", effAddr, ea);
    chk1(tag, "memAccess", memAccess, mem);
    chk1(tag, "isImm", isImm, imm);
    chk1(tag, "illegal", illegal, ill);
    chk1(tag, "wbEn", wbEn, wb);
    if (wb) begin
      chk32(tag, "wbData", wbData, wbd);
      chk32(tag, "wbReg", {28'd0, wbReg}, {28'd0, a});
    end
    @(posedge clk);
    if (rstN) begin
      if (ld) refRegs[ldSel] = ldVal;
      if (wb) refRegs[a] = wbd;
    end
  endtask

  task automatic load(input logic [3:0] sel, input logic [31:0] val);
    op(1'b0, 4'd0, 4'd0, 4'd0, 2'd0, 16'd0, "R12", 1'b1, sel, val);
  endtask

  task automatic readReg(input logic [3:0] sel, input string tag);
    op(1'b1, 4'd0, sel, 4'd0, 2'd0, 16'd0, tag);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) refRegs[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: every register zero after reset
    for (int i = 0; i < 16; i++) readReg(4'(i), "R1");

    // R12: result write port loads
    load(4'd1, 32'h0000_1000);
    load(4'd2, 32'h0000_0005);
    load(4'd3, 32'hFFFF_FFF0);
    load(4'd4, 32'h8000_0000);
    load(4'd15, 32'h0000_2000);
    readReg(4'd1, "R12");
    readReg(4'd3, "R12");
    readReg(4'd15, "R2");

    // R3 immediate, R4 absolute
    op(1'b1, 4'd1, 4'd0, 4'd0, 2'd0, 16'h8001, "R3");
    op(1'b1, 4'd1, 4'd0, 4'd0, 2'd0, 16'h1234, "R3");
    op(1'b1, 4'd2, 4'd0, 4'd0, 2'd0, 16'h8001, "R4");

    // R5 indirect and base plus offset
    op(1'b1, 4'd3, 4'd1, 4'd0, 2'd0, 16'h0000, "R5");
    op(1'b1, 4'd4, 4'd1, 4'd0, 2'd0, 16'hFFFC, "R5");
    op(1'b1, 4'd4, 4'd1, 4'd0, 2'd0, 16'h0010, "R5");
    op(1'b1, 4'd4, 4'd1, 4'd0, 2'd0, 16'h0000, "R5");
    op(1'b1, 4'd4, 4'd4, 4'd0, 2'd0, 16'h7FFF, "R5");

    // R6 indexed, every scale, negative index
    for (int s = 0; s < 4; s++) op(1'b1, 4'd5, 4'd1, 4'd2, 2'(s), 16'd0, "R6");
    op(1'b1, 4'd5, 4'd1, 4'd3, 2'd1, 16'd0, "R6");
    op(1'b1, 4'd6, 4'd1, 4'd2, 2'd2, 16'hFFFF, "R6");
    op(1'b1, 4'd6, 4'd1, 4'd3, 2'd3, 16'h0100, "R6");

    // R7 PC-relative
    pcIn = 32'h0000_0400;
    op(1'b1, 4'd7, 4'd0, 4'd0, 2'd0, 16'hFFF0, "R7");
    op(1'b1, 4'd7, 4'd0, 4'd0, 2'd0, 16'h0020, "R7");

    // R8 post-increment
    op(1'b1, 4'd8, 4'd1, 4'd0, 2'd2, 16'd0, "R8");
    op(1'b1, 4'd8, 4'd1, 4'd0, 2'd0, 16'd0, "R8");
    readReg(4'd1, "R8");

    // R9 stack: two pushes, two pops
    op(1'b1, 4'd9, 4'd15, 4'd0, 2'd2, 16'd0, "R9");
    op(1'b1, 4'd9, 4'd15, 4'd0, 2'd2, 16'd0, "R9");
    op(1'b1, 4'd8, 4'd15, 4'd0, 2'd2, 16'd0, "R9");
    op(1'b1, 4'd8, 4'd15, 4'd0, 2'd2, 16'd0, "R9");
    readReg(4'd15, "R9");
    chk32("R9", "pointer restored", refRegs[15], 32'h0000_2000);

    // R10 undefined codes leave register unchanged
    for (int m = 10; m < 16; m++) op(1'b1, 4'(m), 4'd1, 4'd0, 2'd1, 16'd4, "R10");
    readReg(4'd1, "R10");

    // R11 strobe low: no flags, no writeback
    op(1'b0, 4'd8, 4'd1, 4'd0, 2'd3, 16'd0, "R11");
    op(1'b0, 4'd9, 4'd1, 4'd0, 2'd3, 16'd0, "R11");
    op(1'b0, 4'd1, 4'd1, 4'd0, 2'd0, 16'd0, "R11");
    readReg(4'd1, "R11");

    // R12 collision: writeback wins; separate registers both update
    op(1'b1, 4'd8, 4'd2, 4'd0, 2'd0, 16'd0, "R12", 1'b1, 4'd2, 32'h0000_ABCD);
    readReg(4'd2, "R12");
    op(1'b1, 4'd9, 4'd1, 4'd0, 2'd1, 16'd0, "R12", 1'b1, 4'd5, 32'h1234_5678);
    readReg(4'd1, "R12");
    readReg(4'd5, "R12");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule